// File: doc/BRIEF.md
# Link Bring-Up and Speed-Change Controller

This block sequences the start of a serial link. On a start request it first caps the allowed link speed at generation 1, then enables training and waits for the link to report itself up with training finished. When the requested target is generation 2, it raises the speed cap to 2 and issues a directed speed-change request. It then waits a bounded time for the self-clearing request bit to drop, unless that wait is switched off for the variant at hand. Finally it waits for the link to settle again. On success it reports the negotiated speed read from the link status.

When any wait runs out, the block recovers the PHY receiver through a simple register-access port. It reads PHY register 0x1005, sets the receiver-data-enable and PLL-enable override bits, and writes the value back. It holds that state for a fixed number of cycles, then reads the register again, clears the two bits and writes it back. It then reports an error. Link training itself sits outside the block.

States: `ST_IDLE`, `ST_CAP` (cap speed at 1), `ST_TRAIN` (first link wait), `ST_RAISE` (cap at 2, request speed change), `ST_POLL` (bounded wait for the request bit to clear), `ST_RETRAIN` (second link wait), `ST_REPORT` (success), `ST_RD_SET`, `ST_WR_SET`, `ST_HOLD`, `ST_RD_CLR`, `ST_WR_CLR` (recovery) and `ST_FAIL` (error report).

Transitions:
- IDLE→CAP on start.
- CAP→TRAIN always.
- TRAIN→RAISE when the link is ready and the target is 2; TRAIN→REPORT when the link is ready and the target is 1; TRAIN→RD_SET on timeout.
- RAISE→RETRAIN when the wait is skipped, else RAISE→POLL.
- POLL→RETRAIN when a sample finds the bit clear; POLL→RD_SET when the last sample finds it set.
- RETRAIN→REPORT when the link is ready; RETRAIN→RD_SET on timeout.
- RD_SET→WR_SET→HOLD on acknowledges; HOLD→RD_CLR after the hold time; RD_CLR→WR_CLR→FAIL on acknowledges.
- REPORT→IDLE and FAIL→IDLE always.

Top module: `link_speed_bringup`

## Requirements
- R1: After reset, `train_en_o`=0, `max_speed_o`=2, `speed_change_o`=0, `phy_req_o`=0, `done_o`=0, `err_o`=0 and `speed_o`=0.
- R2: A start accepted in idle sets `max_speed_o` to 1 on that clock edge and drops `train_en_o`; `train_en_o` rises on the next edge, so it never rises while the cap differs from 1.
- R3: The link counts as ready only when `link_up_i`=1 and `in_training_i`=0. Each link wait gives up after LINK_TIMEOUT cycles and enters recovery. When readiness and expiry fall in the same cycle, readiness wins.
- R4: With target generation 2, once the first wait succeeds, `max_speed_o` becomes 2 and `speed_change_o` pulses for exactly one cycle while the cap reads 2.
- R5: Without the skip option, `spd_chg_pend_i` is sampled every POLL_GAP cycles, at most POLL_MAX times. A sample that finds it 0 moves on to the second link wait. If the last sample finds it 1, the block enters recovery; a clear seen at that last sample still counts as success.
- R6: When `skip_wait_i` is 1 at start, the block goes straight from the request to the second link wait, and `spd_chg_pend_i` has no effect on the result.
- R7: On success `done_o` pulses for one cycle with `err_o`=0, and `speed_o` holds the value of `cur_speed_i` (bits 19:16 of link status) taken when the final wait succeeded.
- R8: With target generation 1, no speed-change pulse is issued and `max_speed_o` stays 1.
- R9: On failure the PHY port performs, in order: read of address 0x1005; write of the read value OR 0x0028 (bit 5 receiver data enable, bit 3 PLL enable); RX_HOLD cycles with no request; read of 0x1005; write of the read value AND NOT 0x0028. Then `done_o` pulses with `err_o`=1 and `speed_o`=0.
- R10: A start while not idle is ignored: the speed cap, training enable and outcome are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a bring-up (accepted only in idle) |
| target_gen2_i | input | 1 | 1: target generation 2, 0: stay at generation 1 |
| skip_wait_i | input | 1 | 1: skip the wait for the speed-change bit to clear |
| link_up_i | input | 1 | Link-up status (debug status bit 4) |
| in_training_i | input | 1 | Link in training (debug status bit 29) |
| cur_speed_i | input | 4 | Current link speed (link status bits 19:16) |
| spd_chg_pend_i | input | 1 | Directed speed-change bit still set |
| phy_ack_i | input | 1 | PHY access acknowledge, one-cycle pulse |
| phy_rdata_i | input | 16 | PHY read data, valid with acknowledge |
| train_en_o | output | 1 | Training enable |
| max_speed_o | output | 4 | Maximum allowed link speed field |
| speed_change_o | output | 1 | One-cycle pulse setting the directed speed-change bit (bit 17) |
| phy_req_o | output | 1 | PHY access request, held until acknowledge |
| phy_we_o | output | 1 | PHY access is a write |
| phy_addr_o | output | 16 | PHY register address |
| phy_wdata_o | output | 16 | PHY write data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last bring-up failed |
| speed_o | output | 4 | Negotiated speed of last successful bring-up |

## Verification
Two pairs of events can coincide. The link can become ready in the very cycle its wait expires. The speed-change bit can clear exactly at the last permitted poll sample. The bench provokes the first with link delays of LINK_TIMEOUT and LINK_TIMEOUT+1 cycles, and the second with clear delays that land exactly at, and one cycle past, the final sample. It judges by `err_o` and `speed_o` at the completion pulse: the on-boundary case must succeed and the one-past case must enter recovery.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CAP,
        ST_TRAIN,
        ST_RAISE,
        ST_POLL,
        ST_RETRAIN,
        ST_REPORT,
        ST_RD_SET,
        ST_WR_SET,
        ST_HOLD,
        ST_RD_CLR,
        ST_WR_CLR,
        ST_FAIL
    } lsb_state_e;

    localparam logic [3:0]  SPEED_GEN1   = 4'd1;
    localparam logic [3:0]  SPEED_GEN2   = 4'd2;
    localparam logic [15:0] RX_OVRD_ADDR = 16'h1005;
    localparam logic [15:0] RX_OVRD_MASK = 16'h0028;

endpackage

// File: rtl/lsb_timer.sv
module lsb_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != {W{1'b1}})
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lsb_poll_counter.sv
module lsb_poll_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/link_speed_bringup.sv
module link_speed_bringup
    import lsb_pkg::*;
#(
    parameter int LINK_TIMEOUT = 1000,
    parameter int POLL_GAP     = 16,
    parameter int POLL_MAX     = 200,
    parameter int RX_HOLD      = 500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        target_gen2_i,
    input  logic        skip_wait_i,
    input  logic        link_up_i,
    input  logic        in_training_i,
    input  logic [3:0]  cur_speed_i,
    input  logic        spd_chg_pend_i,
    input  logic        phy_ack_i,
    input  logic [15:0] phy_rdata_i,
    output logic        train_en_o,
    output logic [3:0]  max_speed_o,
    output logic        speed_change_o,
    output logic        phy_req_o,
    output logic        phy_we_o,
    output logic [15:0] phy_addr_o,
    output logic [15:0] phy_wdata_o,
    output logic        done_o,
    output logic        err_o,
    output logic [3:0]  speed_o
);
    localparam int TMAX_A = (LINK_TIMEOUT > POLL_GAP) ? LINK_TIMEOUT : POLL_GAP;
    localparam int TMAX   = (TMAX_A > RX_HOLD) ? TMAX_A : RX_HOLD;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int PW     = $clog2(POLL_MAX + 1);

    lsb_state_e  state_q, state_d;
    logic [TW-1:0] tmr_cnt;
    logic [PW-1:0] poll_cnt;
    logic        link_ok, link_expired, poll_tick, hold_over, tmr_clr;
    logic [3:0]  max_spd_q, spd_q;
    logic        train_en_q, gen2_q, skip_q, err_q;
    logic [15:0] phy_data_q;

    assign link_ok      = link_up_i & ~in_training_i;
    assign link_expired = (tmr_cnt == TW'(LINK_TIMEOUT - 1));
    assign poll_tick    = (state_q == ST_POLL) && (tmr_cnt == TW'(POLL_GAP - 1));
    assign hold_over    = (tmr_cnt == TW'(RX_HOLD - 1));
    assign tmr_clr      = (state_d != state_q) || poll_tick;

    lsb_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (tmr_cnt)
    );

    lsb_poll_counter #(.W(PW)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_POLL),
        .inc   (poll_tick),
        .cnt   (poll_cnt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_CAP;
            ST_CAP:     state_d = ST_TRAIN;
            ST_TRAIN: begin
                if (link_ok)           state_d = gen2_q ? ST_RAISE : ST_REPORT;
                else if (link_expired) state_d = ST_RD_SET;
            end
            ST_RAISE:   state_d = skip_q ? ST_RETRAIN : ST_POLL;
            ST_POLL: begin
                if (poll_tick) begin
                    if (!spd_chg_pend_i)                     state_d = ST_RETRAIN;
                    else if (poll_cnt == PW'(POLL_MAX - 1))  state_d = ST_RD_SET;
                end
            end
            ST_RETRAIN: begin
                if (link_ok)           state_d = ST_REPORT;
                else if (link_expired) state_d = ST_RD_SET;
            end
            ST_REPORT:  state_d = ST_IDLE;
            ST_RD_SET:  if (phy_ack_i) state_d = ST_WR_SET;
            ST_WR_SET:  if (phy_ack_i) state_d = ST_HOLD;
            ST_HOLD:    if (hold_over) state_d = ST_RD_CLR;
            ST_RD_CLR:  if (phy_ack_i) state_d = ST_WR_CLR;
            ST_WR_CLR:  if (phy_ack_i) state_d = ST_FAIL;
            ST_FAIL:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // register model and result datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            max_spd_q  <= SPEED_GEN2;
            train_en_q <= 1'b0;
            gen2_q     <= 1'b0;
            skip_q     <= 1'b0;
            err_q      <= 1'b0;
            spd_q      <= '0;
            phy_data_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                max_spd_q  <= SPEED_GEN1;
                train_en_q <= 1'b0;
                gen2_q     <= target_gen2_i;
                skip_q     <= skip_wait_i;
                err_q      <= 1'b0;
                spd_q      <= '0;
            end
            if (state_q == ST_CAP)
                train_en_q <= 1'b1;
            if (state_q == ST_TRAIN && state_d == ST_RAISE)
                max_spd_q <= SPEED_GEN2;
            if (state_q != ST_REPORT && state_d == ST_REPORT)
                spd_q <= cur_speed_i;
            if (state_q == ST_RD_SET && phy_ack_i)
                phy_data_q <= phy_rdata_i | RX_OVRD_MASK;
            if (state_q == ST_RD_CLR && phy_ack_i)
                phy_data_q <= phy_rdata_i & ~RX_OVRD_MASK;
            if (state_q == ST_WR_CLR && phy_ack_i) begin
                err_q <= 1'b1;
                spd_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        speed_change_o = (state_q == ST_RAISE);
        phy_req_o      = (state_q == ST_RD_SET) || (state_q == ST_WR_SET) ||
                         (state_q == ST_RD_CLR) || (state_q == ST_WR_CLR);
        phy_we_o       = (state_q == ST_WR_SET) || (state_q == ST_WR_CLR);
        phy_addr_o     = RX_OVRD_ADDR;
        phy_wdata_o    = phy_we_o ? phy_data_q : 16'h0000;
        done_o         = (state_q == ST_REPORT) || (state_q == ST_FAIL);
        err_o          = err_q;
        speed_o        = spd_q;
        max_speed_o    = max_spd_q;
        train_en_o     = train_en_q;
    end
endmodule

// File: rtl/link_speed_bringup_chk.sv
module link_speed_bringup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       train_en_o,
    input logic [3:0] max_speed_o,
    input logic       speed_change_o,
    input logic       phy_req_o,
    input logic       done_o,
    input logic       err_o,
    input logic [3:0] speed_o
);
    assert_train_at_gen1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en_o) |-> max_speed_o == 4'd1);

    assert_change_at_gen2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        speed_change_o |-> max_speed_o == 4'd2);

    assert_change_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        speed_change_o |=> !speed_change_o);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_fail_speed_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> speed_o == 4'd0);

    assert_recover_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        phy_req_o |-> (!speed_change_o && !done_o && train_en_o));
endmodule

bind link_speed_bringup link_speed_bringup_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .train_en_o     (train_en_o),
    .max_speed_o    (max_speed_o),
    .speed_change_o (speed_change_o),
    .phy_req_o      (phy_req_o),
    .done_o         (done_o),
    .err_o          (err_o),
    .speed_o        (speed_o)
);

// File: tb/test_link_speed_bringup.sv
`timescale 1ns/1ps
module test_link_speed_bringup;
    localparam int LT = 40;
    localparam int PG = 3;
    localparam int PM = 4;
    localparam int RH = 20;
    localparam logic [15:0] NEVER = 16'hFFFF;
    localparam logic [15:0] PHY_INIT = 16'h0104;

    typedef struct packed {
        logic        gen2;
        logic        skip;
        logic [15:0] link_dly;
        logic [15:0] pend_dly;
        logic [15:0] rt_dly;
        logic [3:0]  cur;
        logic        exp_err;
        logic [3:0]  exp_spd;
        logic [3:0]  exp_max;
        logic [1:0]  exp_pulses;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'd5,  NEVER,  NEVER, 4'd1, 1'b0, 4'd1, 4'd1, 2'd0}, // R8 R7
        '{1'b1, 1'b0, 16'd8,  16'd5,  16'd6, 4'd2, 1'b0, 4'd2, 4'd2, 2'd1}, // R4 R5
        '{1'b1, 1'b1, 16'd3,  NEVER,  16'd4, 4'd1, 1'b0, 4'd1, 4'd2, 2'd1}, // R6
        '{1'b0, 1'b0, NEVER,  NEVER,  NEVER, 4'd1, 1'b1, 4'd0, 4'd1, 2'd0}, // R3 R9
        '{1'b1, 1'b0, 16'd4,  NEVER,  16'd2, 4'd2, 1'b1, 4'd0, 4'd2, 2'd1}, // R5
        '{1'b1, 1'b0, 16'd4,  16'd3,  NEVER, 4'd2, 1'b1, 4'd0, 4'd2, 2'd1}, // R3 retrain
        '{1'b0, 1'b0, 16'd40, NEVER,  NEVER, 4'd1, 1'b0, 4'd1, 4'd1, 2'd0}, // R3 boundary
        '{1'b0, 1'b0, 16'd41, NEVER,  NEVER, 4'd1, 1'b1, 4'd0, 4'd1, 2'd0}, // R3 past
        '{1'b1, 1'b0, 16'd2,  16'd12, 16'd1, 4'd2, 1'b0, 4'd2, 4'd2, 2'd1}, // R5 boundary
        '{1'b1, 1'b0, 16'd2,  16'd13, 16'd1, 4'd2, 1'b1, 4'd0, 4'd2, 2'd1}  // R5 past
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, target_gen2_i = 1'b0, skip_wait_i = 1'b0;
    logic link_up_i = 1'b0, in_training_i = 1'b0, spd_chg_pend_i = 1'b0;
    logic [3:0] cur_speed_i = 4'd0;
    logic phy_ack_i = 1'b0;
    logic [15:0] phy_rdata_i = 16'h0;
    logic train_en_o, speed_change_o, phy_req_o, phy_we_o, done_o, err_o;
    logic [3:0] max_speed_o, speed_o;
    logic [15:0] phy_addr_o, phy_wdata_o;

    always #2 clk = ~clk;

    link_speed_bringup #(.LINK_TIMEOUT(LT), .POLL_GAP(PG), .POLL_MAX(PM), .RX_HOLD(RH))
    i_link_speed_bringup (.*);

    int n_checks = 0, n_fail = 0;
    logic [15:0] cfg_link = NEVER, cfg_pend = NEVER, cfg_rt = NEVER;
    int link_cnt = 0, pend_left = 0, rt_left = 0, req_cnt = 0;
    int pulses = 0, wr_cnt = 0, rd_cnt = 0, gap = 0, bad_addr = 0;
    int r2_bad = 0;
    logic prev_train = 1'b0;
    logic [15:0] phy_reg = PHY_INIT;
    logic [15:0] wr_data [2];

    // link and PHY models, driven away from the active edge
    always @(negedge clk) begin
        if (!train_en_o) begin
            link_cnt = 0; pend_left = 0; rt_left = 0;
        end else begin
            link_cnt++;
            if (speed_change_o) begin
                pulses++;
                pend_left = (cfg_pend == NEVER) ? -1 : int'(cfg_pend);
                rt_left   = (cfg_rt == NEVER) ? -1 : int'(cfg_rt);
            end else begin
                if (pend_left > 0) pend_left--;
                if (rt_left > 0) rt_left--;
            end
        end
        link_up_i      = train_en_o && (cfg_link != NEVER) && (link_cnt >= int'(cfg_link));
        in_training_i  = train_en_o && (!link_up_i || rt_left != 0);
        spd_chg_pend_i = (pend_left != 0);
        if (train_en_o && !prev_train && max_speed_o != 4'd1) r2_bad++;
        prev_train = train_en_o;
        phy_ack_i = 1'b0;
        if (phy_req_o) begin
            gap = (wr_cnt == 1) ? gap : gap;
            req_cnt++;
            if (req_cnt == 2) begin
                req_cnt = 0;
                phy_ack_i = 1'b1;
                if (phy_addr_o != 16'h1005) bad_addr++;
                if (phy_we_o) begin
                    if (wr_cnt < 2) wr_data[wr_cnt] = phy_wdata_o;
                    phy_reg = phy_wdata_o;
                    wr_cnt++;
                end else begin
                    phy_rdata_i = phy_reg;
                    rd_cnt++;
                end
            end
        end else begin
            req_cnt = 0;
            if (wr_cnt == 1 && rd_cnt == 1) gap++;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start_run(input logic g2, input logic sk);
        @(negedge clk);
        pulses = 0; wr_cnt = 0; rd_cnt = 0; gap = 0;
        target_gen2_i = g2; skip_wait_i = sk; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output logic ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done_o) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic ok;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(train_en_o == 1'b0, "R1 train_en", int'(train_en_o), 0);
        check(max_speed_o == 4'd2, "R1 max_speed", int'(max_speed_o), 2);
        check(!done_o && !err_o && speed_o == 4'd0 && !phy_req_o && !speed_change_o,
              "R1 outputs", int'(speed_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 directed: cap first, training one cycle later
        cfg_link = 16'd5; cfg_pend = NEVER; cfg_rt = NEVER; cur_speed_i = 4'd1;
        start_run(1'b0, 1'b0);
        check(max_speed_o == 4'd1, "R2 cap at start", int'(max_speed_o), 1);
        check(train_en_o == 1'b0, "R2 training held", int'(train_en_o), 0);
        @(negedge clk);
        check(train_en_o == 1'b1, "R2 training on", int'(train_en_o), 1);
        wait_done(ok);
        check(ok, "R7 done seen", int'(ok), 1);

        // vector table
        for (int v = 0; v < NV; v++) begin
            cfg_link = VECS[v].link_dly; cfg_pend = VECS[v].pend_dly;
            cfg_rt = VECS[v].rt_dly; cur_speed_i = VECS[v].cur;
            phy_reg = PHY_INIT;
            start_run(VECS[v].gen2, VECS[v].skip);
            wait_done(ok);
            check(ok, $sformatf("R7 done vec%0d", v), int'(ok), 1);
            check(err_o == VECS[v].exp_err, $sformatf("R3 R5 R9 err vec%0d", v),
                  int'(err_o), int'(VECS[v].exp_err));
            check(speed_o == VECS[v].exp_spd, $sformatf("R7 speed vec%0d", v),
                  int'(speed_o), int'(VECS[v].exp_spd));
            check(max_speed_o == VECS[v].exp_max, $sformatf("R4 R8 max vec%0d", v),
                  int'(max_speed_o), int'(VECS[v].exp_max));
            check(pulses == int'(VECS[v].exp_pulses), $sformatf("R4 R8 pulses vec%0d", v),
                  pulses, int'(VECS[v].exp_pulses));
            check(wr_cnt == (VECS[v].exp_err ? 2 : 0), $sformatf("R9 writes vec%0d", v),
                  wr_cnt, VECS[v].exp_err ? 2 : 0);
            if (VECS[v].exp_err) begin
                check(wr_data[0] == (PHY_INIT | 16'h0028), $sformatf("R9 set value vec%0d", v),
                      int'(wr_data[0]), int'(PHY_INIT | 16'h0028));
                check(wr_data[1] == PHY_INIT, $sformatf("R9 clear value vec%0d", v),
                      int'(wr_data[1]), int'(PHY_INIT));
                check(gap == RH, $sformatf("R9 hold vec%0d", v), gap, RH);
            end
            @(negedge clk);
            check(done_o == 1'b0, $sformatf("R7 single done vec%0d", v), int'(done_o), 0);
        end

        // R9 with all other bits set
        cfg_link = NEVER; phy_reg = 16'hFFD7;
        start_run(1'b0, 1'b0);
        wait_done(ok);
        check(wr_data[0] == 16'hFFFF, "R9 set keeps bits", int'(wr_data[0]), 16'hFFFF);
        check(wr_data[1] == 16'hFFD7, "R9 clear keeps bits", int'(wr_data[1]), 16'hFFD7);
        check(bad_addr == 0, "R9 address", bad_addr, 0);

        // R10 start ignored while polling
        cfg_link = 16'd4; cfg_pend = NEVER; cfg_rt = 16'd2; phy_reg = PHY_INIT;
        start_run(1'b1, 1'b0);
        for (int i = 0; i < 100 && pulses == 0; i++) @(negedge clk);
        @(negedge clk);
        target_gen2_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(max_speed_o == 4'd2, "R10 cap unchanged", int'(max_speed_o), 2);
        check(train_en_o == 1'b1, "R10 training unchanged", int'(train_en_o), 1);
        wait_done(ok);
        check(err_o == 1'b1, "R10 outcome unchanged", int'(err_o), 1);

        // R6 skip ignores a pending bit that never clears, R2 global monitor
        cfg_link = 16'd3; cfg_pend = NEVER; cfg_rt = 16'd1; cur_speed_i = 4'd2;
        start_run(1'b1, 1'b1);
        wait_done(ok);
        check(err_o == 1'b0 && speed_o == 4'd2, "R6 skip success", int'(speed_o), 2);
        check(r2_bad == 0, "R2 rise only at cap 1", r2_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule